// File: doc/BRIEF.md
# Game-Controller Report Decoder with Clock-Domain Hand-Off

This block sits behind a byte-oriented serial receiver that carries button reports from a wireless game controller. It works in the receiver's clock domain. It finds the start of each four-byte report by looking for a fixed two-byte header. It then collects the two payload bytes into a 16-bit button word. A header that starts correctly but does not finish correctly raises a short error flag, and the parser goes back to searching.

A finished button word goes into a holding register in the source domain, and an enable bit toggles. The toggle reaches the system clock domain through a synchronizer chain. An edge on the synchronized toggle lets a multiplexer load the held word into the output register. At all other times the output register feeds its own value back to itself. The consumer therefore only ever sees a whole word. Each load comes with a one-cycle update strobe. The controller sends reports only when a button changes, so the strobe marks a change of button state.

Top module: `ctrl_report_cdc`

## Requirements
- R1: While rst_ni is low and after it is released, btn_o is all zeros, and upd_o and hdr_err_o are low until the input stream causes an event.
- R2: Four accepted bytes 0xA1, 0x30, H, L make btn_o equal {H, L}, with the third byte in bits 15:8 and the fourth byte in bits 7:0.
- R3: While searching for a header, any accepted byte other than 0xA1 is discarded without raising hdr_err_o and without changing btn_o or pulsing upd_o.
- R4: An accepted byte that follows 0xA1 and is not 0x30 drives hdr_err_o high for exactly one source clock cycle and returns the parser to searching, and no word is delivered.
- R5: After a broken header, the next 0xA1, 0x30, H, L sequence is decoded normally.
- R6: Payload bytes may take any value, including 0xA1 and 0x30, and are delivered as data without disturbing the framing of later reports.
- R7: Cycles with byte_vld_i low neither advance the parser nor alter any state, so bytes separated by idle cycles frame the same way as back-to-back bytes.
- R8: Each delivered word gives exactly one upd_o pulse of one destination cycle, in the cycle where btn_o takes the new value, and btn_o does not change in any other cycle.
- R9: A report completed before the previous one has been taken into the destination domain replaces the held word, so after the stream goes quiet btn_o equals the most recent report.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk_i | input | 1 | Clock of the byte stream |
| dst_clk_i | input | 1 | Clock of the consumer |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| byte_vld_i | input | 1 | byte_i holds a received byte this source cycle |
| byte_i | input | 8 | Received byte |
| hdr_err_o | output | 1 | One-cycle pulse (source domain) when the second header byte is wrong |
| btn_o | output | 16 | Button word (destination domain) |
| upd_o | output | 1 | One-cycle pulse (destination domain) when btn_o is loaded |

## Verification
The bench targets header bytes that show up where they do not belong. A stray 0xA1 right after a good 0xA1 must produce an error. Header-valued bytes inside the payload must be taken as data. A parser that resynchronizes inside the payload would deliver a wrong word or drop the next report. Noise before a header, and idle gaps inside a report, would expose a parser that counts cycles rather than accepted bytes, or that flags errors while it is only searching. Two reports sent back to back check that the last one survives. A crossing that sampled the data bits one at a time, or that strobed twice for one toggle, would show a stale word or an extra update.

// File: rtl/ctrl_rpt_pkg.sv
package ctrl_rpt_pkg;
  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_CHAN = 2'd1,
    ST_HI   = 2'd2,
    ST_LO   = 2'd3
  } frm_st_e;
endpackage

// File: rtl/rpt_framer.sv
module rpt_framer #(
  parameter int          BYTE_W = 8,
  parameter logic [7:0]  HDR0   = 8'hA1,
  parameter logic [7:0]  HDR1   = 8'h30,
  localparam int         WORD_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              done_o,
  output logic [WORD_W-1:0] word_o,
  output logic              hdr_err_o
);
  import ctrl_rpt_pkg::*;

  frm_st_e           st_q, st_d;
  logic [BYTE_W-1:0] hi_q;
  logic              err_q, err_d;

  always_comb begin
    st_d  = st_q;
    err_d = 1'b0;
    if (vld_i) begin
      unique case (st_q)
        ST_HUNT: if (byte_i == BYTE_W'(HDR0)) st_d = ST_CHAN;
        ST_CHAN: begin
          if (byte_i == BYTE_W'(HDR1)) st_d = ST_HI;
          else begin
            st_d  = ST_HUNT;
            err_d = 1'b1;
          end
        end
        ST_HI:   st_d = ST_LO;
        ST_LO:   st_d = ST_HUNT;
        default: st_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_HUNT;
      hi_q  <= '0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      err_q <= err_d;
      if (vld_i && st_q == ST_HI) hi_q <= byte_i;
    end
  end

  assign done_o    = vld_i && (st_q == ST_LO);
  assign word_o    = {hi_q, byte_i};
  assign hdr_err_o = err_q;
endmodule

// File: rtl/cdc_hold_tx.sv
module cdc_hold_tx #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] hold_o,
  output logic         tog_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_o <= '0;
      tog_o  <= 1'b0;
    end else if (load_i) begin
      hold_o <= word_i;
      tog_o  <= ~tog_o;
    end
  end
endmodule

// File: rtl/cdc_mux_rx.sv
module cdc_mux_rx #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tog_i,
  input  logic [W-1:0] hold_i,
  output logic [W-1:0] word_o,
  output logic         upd_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              sel;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= tog_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], tog_i};
      end
    end
  endgenerate

  assign sel = sync_q[STAGES-1] ^ prev_q;

  // held word is quiet by the time sel rises; otherwise recirculate
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      word_o <= '0;
      upd_o  <= 1'b0;
    end else begin
      prev_q <= sync_q[STAGES-1];
      word_o <= sel ? hold_i : word_o;
      upd_o  <= sel;
    end
  end
endmodule

// File: rtl/ctrl_report_cdc.sv
module ctrl_report_cdc #(
  parameter int         BYTE_W      = 8,
  parameter logic [7:0] HDR0        = 8'hA1,
  parameter logic [7:0] HDR1        = 8'h30,
  parameter int         SYNC_STAGES = 2,
  localparam int        WORD_W      = 2 * BYTE_W
) (
  input  logic              src_clk_i,
  input  logic              dst_clk_i,
  input  logic              rst_ni,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              hdr_err_o,
  output logic [WORD_W-1:0] btn_o,
  output logic              upd_o
);
  logic              done_w;
  logic [WORD_W-1:0] word_w;
  logic [WORD_W-1:0] hold_w;
  logic              tog_w;

  rpt_framer #(.BYTE_W(BYTE_W), .HDR0(HDR0), .HDR1(HDR1)) u_framer (
    .clk_i    (src_clk_i),
    .rst_ni   (rst_ni),
    .vld_i    (byte_vld_i),
    .byte_i   (byte_i),
    .done_o   (done_w),
    .word_o   (word_w),
    .hdr_err_o(hdr_err_o)
  );

  cdc_hold_tx #(.W(WORD_W)) u_tx (
    .clk_i (src_clk_i),
    .rst_ni(rst_ni),
    .load_i(done_w),
    .word_i(word_w),
    .hold_o(hold_w),
    .tog_o (tog_w)
  );

  cdc_mux_rx #(.W(WORD_W), .STAGES(SYNC_STAGES)) u_rx (
    .clk_i (dst_clk_i),
    .rst_ni(rst_ni),
    .tog_i (tog_w),
    .hold_i(hold_w),
    .word_o(btn_o),
    .upd_o (upd_o)
  );
endmodule

// File: rtl/ctrl_report_cdc_chk.sv
module ctrl_report_cdc_chk #(
  parameter int W = 16
) (
  input logic         src_clk_i,
  input logic         dst_clk_i,
  input logic         rst_ni,
  input logic         byte_vld_i,
  input logic         hdr_err_o,
  input logic [W-1:0] btn_o,
  input logic         upd_o,
  input logic [W-1:0] hold_w,
  input logic         tog_w
);
  always @(negedge dst_clk_i) begin
    if (!rst_ni) AST_RESET_CLEAR: assert (btn_o == '0 && !upd_o && !hdr_err_o); // R1
  end

  AST_ERR_SINGLE: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
    hdr_err_o |=> !hdr_err_o); // R4

  AST_ERR_NEEDS_BYTE: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
    !byte_vld_i |=> !hdr_err_o); // R7

  AST_IDLE_NO_TOGGLE: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
    !byte_vld_i |=> $stable(tog_w)); // R7

  AST_HOLD_WITH_TOGGLE: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
    $stable(tog_w) |-> $stable(hold_w)); // R9

  AST_BTN_ONLY_ON_UPD: assert property (@(posedge dst_clk_i) disable iff (!rst_ni)
    !upd_o |-> $stable(btn_o)); // R8
endmodule

bind ctrl_report_cdc ctrl_report_cdc_chk #(.W(WORD_W)) u_chk (
  .src_clk_i (src_clk_i),
  .dst_clk_i (dst_clk_i),
  .rst_ni    (rst_ni),
  .byte_vld_i(byte_vld_i),
  .hdr_err_o (hdr_err_o),
  .btn_o     (btn_o),
  .upd_o     (upd_o),
  .hold_w    (hold_w),
  .tog_w     (tog_w)
);

// File: tb/ctrl_report_cdc_bench.sv
`timescale 1ns/1ps
module ctrl_report_cdc_bench;
  logic        src_clk = 1'b0;
  logic        dst_clk = 1'b0;
  logic        rst_n   = 1'b0;
  logic        vld     = 1'b0;
  logic [7:0]  data    = '0;
  logic        hdr_err;
  logic [15:0] btn;
  logic        upd;

  int checks = 0;
  int errors = 0;
  int err_cyc = 0;
  int upd_cnt = 0;
  bit done = 0;

  always #5 dst_clk = ~dst_clk;   // 100 MHz consumer clock
  always #7 src_clk = ~src_clk;

  ctrl_report_cdc u_ctrl_report_cdc (
    .src_clk_i (src_clk),
    .dst_clk_i (dst_clk),
    .rst_ni    (rst_n),
    .byte_vld_i(vld),
    .byte_i    (data),
    .hdr_err_o (hdr_err),
    .btn_o     (btn),
    .upd_o     (upd)
  );

  always @(negedge src_clk) if (rst_n && hdr_err) err_cyc++;
  always @(negedge dst_clk) if (rst_n && upd) upd_cnt++;

  function automatic logic [15:0] exp_word(logic [7:0] hi, logic [7:0] lo);
    return {hi, lo};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(logic [7:0] b);
    @(negedge src_clk);
    vld  = 1'b1;
    data = b;
  endtask

  task automatic idle(int n);
    @(negedge src_clk);
    vld = 1'b0;
    repeat (n - 1) @(negedge src_clk);
  endtask

  task automatic settle();
    idle(2);
    repeat (8) @(negedge dst_clk);
  endtask

  task automatic report(logic [7:0] hi, logic [7:0] lo);
    put(8'hA1); put(8'h30); put(hi); put(lo);
  endtask

  initial begin
    #1ms;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int u0, e0;
    logic [15:0] last;
    void'($urandom(32'd1234));
    repeat (3) @(negedge dst_clk);
    check("R1 btn in reset", btn, 0);
    check("R1 upd in reset", upd, 0);
    check("R1 err in reset", hdr_err, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge dst_clk);
    check("R1 btn after reset", btn, 0);

    // R2 directed
    u0 = upd_cnt; report(8'h12, 8'h34); settle();
    check("R2 word", btn, exp_word(8'h12, 8'h34));
    check("R8 one strobe", upd_cnt - u0, 1);

    // R3 noise while hunting
    u0 = upd_cnt; e0 = err_cyc;
    put(8'h00); put(8'h55); put(8'hFF); put(8'h30); put(8'h12); settle();
    check("R3 no update", upd_cnt - u0, 0);
    check("R3 no error", err_cyc - e0, 0);
    check("R3 btn kept", btn, 16'h1234);

    // R4 bad channel byte, including a repeated 0xA1
    u0 = upd_cnt; e0 = err_cyc;
    put(8'hA1); put(8'h77); put(8'h01); put(8'h02); settle();
    check("R4 one error cycle", err_cyc - e0, 1);
    check("R4 no update", upd_cnt - u0, 0);
    e0 = err_cyc;
    put(8'hA1); put(8'hA1); put(8'h30); put(8'h9A); put(8'hBC); settle();
    check("R4 repeated A1 errors", err_cyc - e0, 1);
    check("R4 no update after A1 A1", upd_cnt - u0, 0);
    check("R4 btn kept", btn, 16'h1234);

    // R5 resync after broken header
    u0 = upd_cnt; e0 = err_cyc;
    put(8'hA1); put(8'h00); report(8'hAB, 8'hCD); settle();
    check("R5 error seen", err_cyc - e0, 1);
    check("R5 word", btn, exp_word(8'hAB, 8'hCD));
    check("R5 strobe", upd_cnt - u0, 1);

    // R6 header values as payload
    u0 = upd_cnt;
    report(8'hA1, 8'h30); settle();
    check("R6 word A130", btn, exp_word(8'hA1, 8'h30));
    report(8'h30, 8'hA1); settle();
    check("R6 word 30A1", btn, exp_word(8'h30, 8'hA1));
    check("R6 strobes", upd_cnt - u0, 2);

    // R7 idle gaps inside a report
    u0 = upd_cnt; e0 = err_cyc;
    put(8'hA1); idle(3); put(8'h30); idle(1); put(8'h5A); idle(5); put(8'hC3); settle();
    check("R7 word with gaps", btn, exp_word(8'h5A, 8'hC3));
    check("R7 strobe", upd_cnt - u0, 1);
    check("R7 no error", err_cyc - e0, 0);

    // R9 back to back reports, last one survives
    u0 = upd_cnt;
    report(8'h11, 8'h22); report(8'h33, 8'h44); settle();
    check("R9 last word", btn, exp_word(8'h33, 8'h44));
    check("R9 strobe count 1..2", (upd_cnt - u0 >= 1 && upd_cnt - u0 <= 2), 1);

    // random reports with random noise prefixes
    for (int i = 0; i < 40; i++) begin
      logic [7:0] hi, lo, junk;
      int nj;
      hi = 8'($urandom); lo = 8'($urandom);
      nj = int'($urandom % 3);
      u0 = upd_cnt; e0 = err_cyc;
      for (int j = 0; j < nj; j++) begin
        junk = 8'($urandom);
        if (junk == 8'hA1) junk = 8'h00;
        put(junk);
        if ($urandom % 2 == 1) idle(1);
      end
      report(hi, lo); settle();
      last = exp_word(hi, lo);
      check("R2 random word", btn, last);
      check("R8 random strobe", upd_cnt - u0, 1);
      check("R3 random no error", err_cyc - e0, 0);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule